// File: doc/BRIEF.md
# Keyed configuration register port

This block exposes a hidden byte-wide configuration register space through two host addresses: an index register at offset 0 and a data register at offset 1. The space is closed after reset. The host opens it by writing a key byte to the index port on two index writes in a row. It closes the space again by writing an exit byte to the index port. While the space is open, the host writes a register number to the index port and then reads or writes that register through the data port.

A device-select register chooses one of several logical devices. Each device has its own pair of base-address bytes. The current base of every device leaves the block on a flat output bus, so the function decoders next to it can relocate themselves. A chip ID and a manufacturer ID are fixed by parameters and are read-only.

Reads are combinational: data appears on the same cycle as the read strobe. Writes take effect on the next rising clock edge.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the space is closed, the device select is 0, the index is 0x00, and every base register holds its parameter reset value (device d at bits [16d+15:16d] of the reset vector and of `dev_base`).
- R2: Writing 0x87 to the index port on two index-port writes in a row opens the space. The two writes need not be on adjacent clock cycles, and data-port writes in between do not count.
- R3: While the space is closed, any index-port write of a value other than 0x87 restarts the key sequence. So 0x87, then 0x12, then 0x87 leaves the space closed, and a later single 0x87 opens it.
- R4: Writing 0xAA to the index port while the space is open closes it, and it does not change the stored index.
- R5: While the space is closed, reads of either port return 0xFF and data-port writes change no register.
- R6: While the space is open, an index-port write other than 0xAA stores the byte as the index, and a read of the index port returns it.
- R7: Index 0x20 reads the chip ID high byte and 0x21 the low byte. Index 0x23 reads the manufacturer ID high byte (default 0x19) and 0x24 the low byte (default 0x34). Data writes to these indices are discarded.
- R8: Index 0x07 is the device-select register. It is readable and writable as a full byte.
- R9: Index 0x60 holds the high byte and 0x61 the low byte of the selected device's base address. Each device keeps its own pair, and the pair is driven on `dev_base`.
- R10: When the device select is NUM_DEV or greater, indices 0x60 and 0x61 read 0x00 and data writes to them change no base register.
- R11: Any index that is not listed in R7 to R10 reads 0x00 while the space is open.
- R12: While `rd_en` is low, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid during `rd_en` |
| dev_base | output | 16*NUM_DEV | Base address of each logical device |

## Verification
The bench builds the block with NUM_DEV = 5, a chip ID of 0x0541 and a distinct reset base for every device. Because five is not a power of two, device numbers 5 to 7 still fit in the select decode but lie outside the bank. This makes the out-of-range path of R10 reachable without a large configuration. The distinct reset bases show whether a read or write landed on the wrong bank, and the non-default chip ID shows that the ID parameters reach the read path.

// File: rtl/cfg_key_port.sv
module cfg_key_port #(
  parameter int          NUM_DEV   = 8,
  parameter logic [7:0]  KEY_BYTE  = 8'h87,
  parameter logic [7:0]  EXIT_BYTE = 8'hAA,
  parameter logic [15:0] CHIP_ID   = 16'h0406,
  parameter logic [15:0] MFR_ID    = 16'h1934,
  parameter logic [NUM_DEV*16-1:0] BASE_RST = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic                  addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic [NUM_DEV*16-1:0] dev_base
);
  localparam int LW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [1:0] S_LOCKED = 2'd0, S_HALF = 2'd1, S_OPEN = 2'd2;
  localparam logic [7:0] IX_SEL = 8'h07, IX_CID_H = 8'h20, IX_CID_L = 8'h21,
                         IX_MID_H = 8'h23, IX_MID_L = 8'h24,
                         IX_BAS_H = 8'h60, IX_BAS_L = 8'h61;

  logic [1:0]  st;
  logic [7:0]  idx, ldn;
  logic [15:0] base_q [NUM_DEV];
  logic [15:0] cur_base;
  logic        idx_wr, data_wr, dev_ok, is_open;

  assign is_open = (st == S_OPEN);
  assign idx_wr  = wr_en && !addr;
  assign data_wr = wr_en && addr && is_open;
  assign dev_ok  = (int'(ldn) < NUM_DEV);
  assign cur_base = dev_ok ? base_q[ldn[LW-1:0]] : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_LOCKED;
      idx <= 8'h00;
    end else if (idx_wr) begin
      case (st)
        S_LOCKED: st <= (wdata == KEY_BYTE) ? S_HALF : S_LOCKED;
        S_HALF:   st <= (wdata == KEY_BYTE) ? S_OPEN : S_LOCKED;
        default: begin
          if (wdata == EXIT_BYTE) st <= S_LOCKED;
          else                    idx <= wdata;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            ldn <= 8'h00;
    else if (data_wr && idx == IX_SEL)     ldn <= wdata;
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic hit;
    assign hit = data_wr && dev_ok && (ldn == 8'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)                         base_q[g] <= BASE_RST[g*16 +: 16];
      else if (hit && idx == IX_BAS_H)    base_q[g][15:8] <= wdata;
      else if (hit && idx == IX_BAS_L)    base_q[g][7:0]  <= wdata;
    end
    assign dev_base[g*16 +: 16] = base_q[g];
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (!is_open)   rdata = 8'hFF;
      else if (!addr) rdata = idx;
      else begin
        case (idx)
          IX_SEL:   rdata = ldn;
          IX_CID_H: rdata = CHIP_ID[15:8];
          IX_CID_L: rdata = CHIP_ID[7:0];
          IX_MID_H: rdata = MFR_ID[15:8];
          IX_MID_L: rdata = MFR_ID[7:0];
          IX_BAS_H: rdata = cur_base[15:8];
          IX_BAS_L: rdata = cur_base[7:0];
          default:  rdata = 8'h00;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_key_port_chk.sv
module cfg_key_port_chk #(
  parameter int         NUM_DEV   = 8,
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] EXIT_BYTE = 8'hAA
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic                  addr,
  input logic [7:0]            wdata,
  input logic [7:0]            rdata,
  input logic [NUM_DEV*16-1:0] dev_base,
  input logic [1:0]            st
);
  a_r2_second_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && wr_en && !addr && wdata == KEY_BYTE) |=> (st == 2'd2));

  a_r3_stray_byte_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd2 && wr_en && !addr && wdata != KEY_BYTE) |=> (st == 2'd0));

  a_r4_exit_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata == EXIT_BYTE && st == 2'd2) |=> (st == 2'd0));

  a_r5_closed_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st != 2'd2) |-> (rdata == 8'hFF));

  a_r5_closed_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd2) |=> $stable(dev_base));

  a_r12_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 8'h00));
endmodule

bind cfg_key_port cfg_key_port_chk #(
  .NUM_DEV(NUM_DEV), .KEY_BYTE(KEY_BYTE), .EXIT_BYTE(EXIT_BYTE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .dev_base(dev_base), .st(st)
);

// File: tb/cfg_key_port_tb.sv
module cfg_key_port_tb;
  localparam int ND = 5;
  localparam logic [ND*16-1:0] BRST = {16'h0A00, 16'h0290, 16'h0378, 16'h03F8, 16'h0060};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [ND*16-1:0] dev_base;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_key_port #(.NUM_DEV(ND), .CHIP_ID(16'h0541), .BASE_RST(BRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dev_base(dev_base));

  // entry: {req, wr, rd, addr, data, expected}
  function automatic logic [22:0] wv(input logic [3:0] r, input logic a, input logic [7:0] d);
    return {r, 1'b1, 1'b0, a, d, 8'h00};
  endfunction
  function automatic logic [22:0] rv(input logic [3:0] r, input logic a, input logic [7:0] e);
    return {r, 1'b0, 1'b1, a, 8'h00, e};
  endfunction

  // R3 broken key, R2 open, R6 index, R7 IDs, R8 select, R9 banks,
  // R10 out-of-range device, R11 unmapped, R4 exit, R5 closed behaviour
  localparam int NV = 54;
  localparam logic [22:0] VEC [NV] = '{
    wv(3,0,8'h87), wv(3,0,8'h12), wv(3,0,8'h87), rv(3,1,8'hFF),
    wv(2,0,8'h87), rv(6,0,8'h00), wv(6,0,8'h20), rv(6,0,8'h20),
    rv(7,1,8'h05), wv(7,0,8'h21), rv(7,1,8'h41), wv(7,0,8'h23),
    rv(7,1,8'h19), wv(7,0,8'h24), rv(7,1,8'h34), wv(7,1,8'hFF),
    rv(7,1,8'h34), wv(8,0,8'h07), rv(8,1,8'h00), wv(8,1,8'h04),
    rv(8,1,8'h04), wv(9,0,8'h60), rv(9,1,8'h0A), wv(9,0,8'h61),
    rv(9,1,8'h00), wv(9,1,8'h80), rv(9,1,8'h80), wv(9,0,8'h60),
    wv(9,1,8'h0B), rv(9,1,8'h0B), wv(9,0,8'h07), wv(9,1,8'h03),
    wv(9,0,8'h60), rv(9,1,8'h02), wv(10,0,8'h07), wv(10,1,8'h05),
    wv(10,0,8'h60), rv(10,1,8'h00), wv(10,1,8'h77), wv(10,0,8'h07),
    wv(10,1,8'h04), wv(10,0,8'h60), rv(10,1,8'h0B), wv(11,0,8'h3F),
    rv(11,1,8'h00), wv(11,0,8'h61), wv(4,0,8'hAA), rv(4,1,8'hFF),
    rv(5,0,8'hFF), wv(5,1,8'h11), wv(5,0,8'h87), wv(5,0,8'h87),
    rv(5,1,8'h80), rv(6,0,8'h61)
  };

  task automatic check(input int r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual 0x%04h expected 0x%04h", r, act, exp);
    end
  endtask

  task automatic check_bases(input int r, input logic [ND*16-1:0] exp);
    for (int d = 0; d < ND; d++) check(r, dev_base[d*16 +: 16], exp[d*16 +: 16]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd_now(input int r, input logic a, input logic [7:0] e);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b1; addr = a; #1;
    check(r, {8'h00, rdata}, {8'h00, e});
  endtask

  initial begin
    logic [ND*16-1:0] exp_b;
    do_reset();
    // R1 reset state: closed, reset bases
    rd_now(1, 1'b1, 8'hFF);
    rd_now(1, 1'b0, 8'hFF);
    check_bases(1, BRST);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      @(negedge clk);
      wr_en = v[18]; rd_en = v[17]; addr = v[16]; wdata = v[15:8];
      #1;
      if (v[17]) check(int'(v[22:19]), {8'h00, rdata}, {8'h00, v[7:0]});
    end

    // R9 modified bank visible on dev_base, others untouched
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; #1;
    exp_b = BRST;
    exp_b[4*16 +: 16] = 16'h0B80;
    check_bases(9, exp_b);
    // R12 idle read data
    addr = 1'b1; #1;
    check(12, {8'h00, rdata}, 16'h0000);

    // R1 reset while open returns to closed state and reset bases
    do_reset();
    rd_now(1, 1'b1, 8'hFF);
    check_bases(1, BRST);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b0; addr = 1'b0; wdata = 8'h87;
    @(negedge clk); wdata = 8'h87;
    rd_now(1, 1'b0, 8'h00);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b0; addr = 1'b0; wdata = 8'h07;
    rd_now(1, 1'b1, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule